// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-Mode Sequencer

This block sits on the controller side of a DDR2 SDRAM. It owns the clock-enable pin and, during power transitions, the four command pins. It takes the memory into and out of its low-power states: active power-down, precharge power-down and self refresh. A scheduler above it raises a power-down request or a self-refresh request. It also supplies a per-bank open flag, a busy flag for any operation still in flight, and a flag for output-driver calibration. The sequencer then decides when the transition is legal and drives it.

The power-down flavour follows from the bank flags. If any bank is open the memory goes to active power-down; if none is open it goes to precharge power-down. Every clock-enable change is followed by a minimum hold. Exits carry only NOP. After self refresh the sequencer forces NOP for a programmable window, then releases general commands, and releases reads later still. Power-down does no refreshing of its own. A deadline timer therefore ends any power-down that runs too long and follows it with an AUTOREFRESH once the banks are idle. A request that cannot be honoured yet is held off and flagged.

Top module: `ddr2_pwr_seq`

## Requirements
- R1: After reset, cke is high, the command pins show DESELECT ({cs_n,ras_n,cas_n,we_n}=1111), cmd_rdy and rd_rdy are high, pwr_mode is 0 (active) and req_deferred is low.
- R2: A power-down request with no bank open, while not busy and not calibrating, drives cke low in the next cycle with NOP (0111) on the command pins and pwr_mode 2 (precharge power-down). The following cycle shows DESELECT.
- R3: The same request with any bank open gives pwr_mode 1 (active power-down).
- R4: A self-refresh request with all banks idle drives cke low together with AUTOREFRESH (0001) and pwr_mode 3. When both requests are present, self refresh wins.
- R5: Once its request is withdrawn, a low-power state is left in the first cycle the hold allows. At that point cke goes high with NOP and pwr_mode returns to 0.
- R6: After any change, cke keeps its new level for at least TCKE cycles. A one-cycle power-down request therefore gives exactly TCKE low cycles.
- R7: While busy or ocd_active is high, no low-power state is entered. cke stays high and req_deferred is high in each cycle that has a pending request. Entry follows in the cycle after the block clears.
- R8: A self-refresh request while any bank is open is not executed: cke stays high and req_deferred is high.
- R9: After self-refresh exit, NOP is driven for TXSNR cycles and cmd_rdy stays low. cmd_rdy rises exactly TXSNR cycles after cke rises. DESELECT follows one cycle later.
- R10: After self-refresh exit, rd_rdy rises exactly TXSRD cycles after cke rises.
- R11: A power-down held past its limit keeps cke low for exactly PD_LIMIT cycles, then raises cke with NOP, then issues AUTOREFRESH in the next cycle if banks are idle and not busy. This also holds when the request is withdrawn in the same cycle the limit expires.
- R12: After a forced exit from active power-down, the block drives DESELECT with cmd_rdy high until no bank is open. It then issues AUTOREFRESH.
- R13: cmd_rdy and rd_rdy are low whenever cke is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | 1 | Power-down request, level |
| sr_req | input | 1 | Self-refresh request, level |
| bank_open | input | NBANK | One flag per bank, high when the bank has an open row |
| busy | input | 1 | A read, write, mode-register, precharge or refresh operation is in flight |
| ocd_active | input | 1 | Output-driver calibration in progress; clock enable must stay high |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cmd_rdy | output | 1 | Scheduler may issue non-read commands |
| rd_rdy | output | 1 | Scheduler may issue reads |
| pwr_mode | output | 2 | 0 active, 1 active power-down, 2 precharge power-down, 3 self refresh |
| req_deferred | output | 1 | A request is pending but blocked by busy, calibration or open banks |

## Verification
Two events can fall in the same cycle: the power-down deadline expiring, and the scheduler withdrawing its power-down request. The bench drops pd_req on the exact edge at which the PD_LIMIT count runs out. It then expects the forced-exit path: cke high with NOP, followed by AUTOREFRESH. A plain exit with no refresh would be wrong there. A second overlap is provoked with self-refresh and power-down requests raised together, and that case is judged by the AUTOREFRESH on the falling cke edge. Each expected pin value is placed in a scoreboard for a specific cycle and compared when that cycle arrives.

// File: rtl/ddr2_pwr_pkg.sv
// Shared types for the DDR2 power-mode sequencer.
// Assumes: command pins are active low and ordered {cs_n,ras_n,cas_n,we_n}.
package ddr2_pwr_pkg;

    // Commands this block can place on the command pins.
    typedef enum logic [1:0] {
        CMD_DES  = 2'd0,
        CMD_NOP  = 2'd1,
        CMD_AREF = 2'd2
    } pwr_cmd_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_ACT  = 3'd0,
        ST_APD  = 3'd1,
        ST_PPD  = 3'd2,
        ST_SR   = 3'd3,
        ST_XSR  = 3'd4,
        ST_REFW = 3'd5
    } pwr_state_e;

    // Externally visible power mode codes.
    localparam logic [1:0] MODE_ACTIVE = 2'd0;
    localparam logic [1:0] MODE_APD    = 2'd1;
    localparam logic [1:0] MODE_PPD    = 2'd2;
    localparam logic [1:0] MODE_SR     = 2'd3;

endpackage

// File: rtl/pwr_sat_timer.sv
// Saturating up-counter that reports when LIMIT cycles have passed since
// its last restart. Restart loads zero; otherwise it counts up to LIMIT and
// holds there. Assumes: LIMIT >= 0; START_DONE selects the reset value
// (saturated, so the condition already holds, or zero).
module pwr_sat_timer #(
    parameter int LIMIT      = 3,
    parameter bit START_DONE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic reached
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count cycles since restart, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= START_DONE ? LIM : '0;
        else if (restart)
            cnt_q <= '0;
        else if (cnt_q < LIM)
            cnt_q <= cnt_q + CW'(1);
    end

    // Flag the elapsed condition from the registered count only.
    always_comb reached = (cnt_q >= LIM);

endmodule

// File: rtl/pwr_cmd_enc.sv
// Maps the internal command code onto the four active-low command pins.
// Assumes: DESELECT drives every pin high; NOP keeps CS low only.
module pwr_cmd_enc
    import ddr2_pwr_pkg::*;
(
    input  pwr_cmd_e cmd,
    output logic     cs_n,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n
);
    // Decode the command into pin levels.
    always_comb begin
        unique case (cmd)
            CMD_NOP:  {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_AREF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default:  {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
    end
endmodule

// File: rtl/ddr2_pwr_seq.sv
// DDR2 clock-enable power-mode sequencer (top).
// Drives cke and, during power transitions, the command pins. It enters
// active or precharge power-down, or self refresh, on request when legal.
// It enforces the cke hold, forces NOP during the post-self-refresh window,
// gates reads for longer, and ends over-long power-down with a refresh.
// Assumes: requests are levels held by the scheduler; the scheduler honours
// cmd_rdy/rd_rdy and raises busy while any operation (including a refresh it
// sees this block issue) is in flight.
module ddr2_pwr_seq
    import ddr2_pwr_pkg::*;
#(
    parameter int NBANK    = 8,
    parameter int TCKE     = 3,
    parameter int TXSNR    = 46,
    parameter int TXSRD    = 200,
    parameter int PD_LIMIT = 3000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req,
    input  logic             sr_req,
    input  logic [NBANK-1:0] bank_open,
    input  logic             busy,
    input  logic             ocd_active,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             cmd_rdy,
    output logic             rd_rdy,
    output logic [1:0]       pwr_mode,
    output logic             req_deferred
);
    localparam int HOLD_LIM = (TCKE > 1) ? TCKE - 1 : 0;
    localparam int DL_LIM   = (PD_LIMIT > TCKE) ? PD_LIMIT - 1 : TCKE - 1;

    pwr_state_e st_q, st_n;
    pwr_cmd_e   cmd_q, cmd_n;
    logic       cke_q, cke_n;
    logic       defer_q, defer_n;

    logic any_open, gate_ok;
    logic hold_ok, xs_ok, rd_ok, ref_due;
    logic hold_rst, xs_rst, dl_rst;

    // Summarise bank status.
    always_comb any_open = |bank_open;

    // Entry is allowed only when the hold is met and nothing forbids it.
    always_comb gate_ok = hold_ok && !busy && !ocd_active;

    // Next-state, next-cke and next-command decision.
    always_comb begin
        st_n    = st_q;
        cke_n   = cke_q;
        cmd_n   = CMD_DES;
        defer_n = 1'b0;
        unique case (st_q)
            ST_ACT: begin
                if (sr_req) begin
                    if (gate_ok && !any_open) begin
                        st_n  = ST_SR;
                        cke_n = 1'b0;
                        cmd_n = CMD_AREF;
                    end else if (busy || ocd_active || any_open) begin
                        defer_n = 1'b1;
                    end
                end else if (pd_req) begin
                    if (gate_ok) begin
                        st_n  = any_open ? ST_APD : ST_PPD;
                        cke_n = 1'b0;
                        cmd_n = CMD_NOP;
                    end else if (busy || ocd_active) begin
                        defer_n = 1'b1;
                    end
                end
            end
            ST_APD, ST_PPD: begin
                if (hold_ok && (ref_due || !pd_req)) begin
                    cke_n = 1'b1;
                    cmd_n = CMD_NOP;
                    st_n  = ref_due ? ST_REFW : ST_ACT;
                end
            end
            ST_SR: begin
                if (hold_ok && !sr_req) begin
                    cke_n = 1'b1;
                    cmd_n = CMD_NOP;
                    st_n  = ST_XSR;
                end
            end
            ST_XSR: begin
                if (xs_ok) st_n = ST_ACT;
                else       cmd_n = CMD_NOP;
            end
            ST_REFW: begin
                if (!any_open && !busy) begin
                    cmd_n = CMD_AREF;
                    st_n  = ST_ACT;
                end
            end
            default: st_n = ST_ACT;
        endcase
    end

    // Timer restart strobes derived from the transition being taken.
    always_comb begin
        hold_rst = (cke_n != cke_q);
        xs_rst   = (st_q == ST_SR) && (st_n == ST_XSR);
        dl_rst   = (st_q == ST_ACT) && ((st_n == ST_APD) || (st_n == ST_PPD));
    end

    // Register state and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_ACT;
            cke_q   <= 1'b1;
            cmd_q   <= CMD_DES;
            defer_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cke_q   <= cke_n;
            cmd_q   <= cmd_n;
            defer_q <= defer_n;
        end
    end

    // cke minimum hold timer.
    pwr_sat_timer #(.LIMIT(HOLD_LIM), .START_DONE(1'b1)) u_hold (
        .clk(clk), .rst_n(rst_n), .restart(hold_rst), .reached(hold_ok));

    // Non-read window after self-refresh exit.
    pwr_sat_timer #(.LIMIT(TXSNR), .START_DONE(1'b1)) u_xsnr (
        .clk(clk), .rst_n(rst_n), .restart(xs_rst), .reached(xs_ok));

    // Read window after self-refresh exit.
    pwr_sat_timer #(.LIMIT(TXSRD), .START_DONE(1'b1)) u_xsrd (
        .clk(clk), .rst_n(rst_n), .restart(xs_rst), .reached(rd_ok));

    // Power-down refresh deadline.
    pwr_sat_timer #(.LIMIT(DL_LIM), .START_DONE(1'b0)) u_dline (
        .clk(clk), .rst_n(rst_n), .restart(dl_rst), .reached(ref_due));

    // Pin encoding of the registered command.
    pwr_cmd_enc u_enc (
        .cmd(cmd_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

    // Ready flags and mode code from the registered state.
    always_comb begin
        cmd_rdy = ((st_q == ST_ACT) || (st_q == ST_REFW) || (st_q == ST_XSR)) && xs_ok;
        rd_rdy  = cmd_rdy && rd_ok;
        unique case (st_q)
            ST_APD:  pwr_mode = MODE_APD;
            ST_PPD:  pwr_mode = MODE_PPD;
            ST_SR:   pwr_mode = MODE_SR;
            default: pwr_mode = MODE_ACTIVE;
        endcase
        cke          = cke_q;
        req_deferred = defer_q;
    end

endmodule

// File: rtl/ddr2_pwr_seq_chk.sv
// Property checker for ddr2_pwr_seq, observing only its ports.
// Keeps its own run-length counters so that long windows need no deep $past.
module ddr2_pwr_seq_chk #(
    parameter int NBANK    = 8,
    parameter int TCKE     = 3,
    parameter int TXSNR    = 46,
    parameter int TXSRD    = 200,
    parameter int PD_LIMIT = 3000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] bank_open,
    input logic             busy,
    input logic             ocd_active,
    input logic             cke,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             cmd_rdy,
    input logic             rd_rdy,
    input logic [1:0]       pwr_mode
);
    logic        prev_cke;
    logic [1:0]  prev_mode;
    logic [15:0] run_cnt, xs_cnt, low_cnt;
    logic        rise, fall, is_nop, is_des, is_aref;

    always_comb begin
        rise    = cke && !prev_cke;
        fall    = !cke && prev_cke;
        is_des  = cs_n;
        is_nop  = !cs_n && ras_n && cas_n && we_n;
        is_aref = !cs_n && !ras_n && !cas_n && we_n;
    end

    // Track level run length, time since self-refresh exit, and low time in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cke  <= 1'b1;
            prev_mode <= 2'd0;
            run_cnt   <= 16'(TCKE);
            xs_cnt    <= 16'(TXSRD);
            low_cnt   <= '0;
        end else begin
            prev_cke  <= cke;
            prev_mode <= pwr_mode;
            if (cke != prev_cke)          run_cnt <= 16'd1;
            else if (run_cnt < 16'(TCKE)) run_cnt <= run_cnt + 16'd1;
            if (rise && prev_mode == 2'd3) xs_cnt <= 16'd1;
            else if (xs_cnt < 16'(TXSRD))  xs_cnt <= xs_cnt + 16'd1;
            if (!cke && (pwr_mode == 2'd1 || pwr_mode == 2'd2)) low_cnt <= low_cnt + 16'd1;
            else                                                low_cnt <= '0;
        end
    end

    // R6
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != prev_cke) |-> (run_cnt >= 16'(TCKE)));

    // R5
    cke_exit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (is_nop || is_des));

    // R2
    cke_entry_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (is_nop || is_aref));

    // R4
    sr_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && is_aref) |-> ($past(bank_open) == '0));

    // R7
    entry_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (!$past(busy) && !$past(ocd_active)));

    // R9
    xsnr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdy |-> (xs_cnt >= 16'(TXSNR)));

    // R10
    xsrd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rdy |-> (xs_cnt >= 16'(TXSRD)));

    // R13
    low_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!cmd_rdy && !rd_rdy));

    // R11
    pd_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && pwr_mode != 2'd3) |-> (low_cnt < 16'(PD_LIMIT)));

endmodule

bind ddr2_pwr_seq ddr2_pwr_seq_chk #(
    .NBANK(NBANK), .TCKE(TCKE), .TXSNR(TXSNR), .TXSRD(TXSRD), .PD_LIMIT(PD_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .busy(busy),
    .ocd_active(ocd_active), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cmd_rdy(cmd_rdy), .rd_rdy(rd_rdy),
    .pwr_mode(pwr_mode)
);

// File: tb/ddr2_pwr_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue expected pin values for given
// cycles; a monitor compares them at the falling edge of that cycle.
module ddr2_pwr_seq_bench;
    localparam int NBANK = 8;
    localparam int TCKE  = 3;
    localparam int TXSNR = 20;
    localparam int TXSRD = 60;
    localparam int PDL   = 40;

    localparam int F_CKE = 0, F_CMD = 1, F_CRDY = 2, F_RRDY = 3, F_DEF = 4, F_MODE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 1'b0, sr_req = 1'b0, busy = 1'b0, ocd_active = 1'b0;
    logic [NBANK-1:0] bank_open = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, cmd_rdy, rd_rdy, req_deferred;
    logic [1:0] pwr_mode;

    int cyc = 0;
    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        int         fld;
        logic [3:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr2_pwr_seq #(.NBANK(NBANK), .TCKE(TCKE), .TXSNR(TXSNR), .TXSRD(TXSRD), .PD_LIMIT(PDL))
    u_ddr2_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .sr_req(sr_req),
        .bank_open(bank_open), .busy(busy), .ocd_active(ocd_active),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd_rdy(cmd_rdy), .rd_rdy(rd_rdy), .pwr_mode(pwr_mode),
        .req_deferred(req_deferred));

    function automatic logic [3:0] field(int f);
        case (f)
            F_CKE:   return {3'b0, cke};
            F_CMD:   return {cs_n, ras_n, cas_n, we_n};
            F_CRDY:  return {3'b0, cmd_rdy};
            F_RRDY:  return {3'b0, rd_rdy};
            F_DEF:   return {3'b0, req_deferred};
            default: return {2'b0, pwr_mode};
        endcase
    endfunction

    // Driver side: queue an expectation d cycles ahead (d >= 1).
    task automatic expect_f(int d, int f, logic [3:0] v, string tag);
        exp_t e;
        e.at = cyc + d; e.fld = f; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every expectation due in this cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at == cyc) begin
                    logic [3:0] got;
                    got = field(sb[i].fld);
                    checks++;
                    if (got !== sb[i].val) begin
                        errs++;
                        $display("FAIL %s cycle %0d field %0d: got %b expected %b",
                                 sb[i].tag, cyc, sb[i].fld, got, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset values
        expect_f(1, F_CKE, 4'h1, "R1"); expect_f(1, F_CMD, 4'hF, "R1");
        expect_f(1, F_CRDY, 4'h1, "R1"); expect_f(1, F_RRDY, 4'h1, "R1");
        expect_f(1, F_DEF, 4'h0, "R1"); expect_f(1, F_MODE, 4'h0, "R1");
        tick(2);

        // R2 / R6 / R5: one-cycle request into precharge power-down
        pd_req = 1'b1;
        expect_f(1, F_CKE, 4'h0, "R2"); expect_f(1, F_CMD, 4'h7, "R2");
        expect_f(1, F_MODE, 4'h2, "R2"); expect_f(1, F_CRDY, 4'h0, "R13");
        expect_f(2, F_CMD, 4'hF, "R2");
        tick(1);
        pd_req = 1'b0;
        expect_f(2, F_CKE, 4'h0, "R6");
        expect_f(3, F_CKE, 4'h1, "R6"); expect_f(3, F_CMD, 4'h7, "R5");
        expect_f(3, F_MODE, 4'h0, "R5"); expect_f(3, F_CRDY, 4'h1, "R5");
        tick(7);

        // R3: active power-down with a bank open
        bank_open = 8'h04; pd_req = 1'b1;
        expect_f(1, F_MODE, 4'h1, "R3"); expect_f(1, F_CKE, 4'h0, "R3");
        tick(10);
        pd_req = 1'b0;
        expect_f(1, F_CKE, 4'h1, "R5"); expect_f(1, F_CMD, 4'h7, "R5");
        expect_f(1, F_MODE, 4'h0, "R5");
        tick(5);
        bank_open = '0;

        // R7: busy holds off entry, then entry the cycle after it clears
        busy = 1'b1; pd_req = 1'b1;
        expect_f(1, F_DEF, 4'h1, "R7"); expect_f(1, F_CKE, 4'h1, "R7");
        expect_f(2, F_DEF, 4'h1, "R7"); expect_f(2, F_CKE, 4'h1, "R7");
        tick(2);
        busy = 1'b0;
        expect_f(1, F_CKE, 4'h0, "R7"); expect_f(1, F_DEF, 4'h0, "R7");
        expect_f(1, F_MODE, 4'h2, "R7");
        tick(1);
        pd_req = 1'b0;
        tick(7);

        // R7: calibration holds cke high
        ocd_active = 1'b1; pd_req = 1'b1;
        expect_f(1, F_DEF, 4'h1, "R7"); expect_f(4, F_CKE, 4'h1, "R7");
        expect_f(4, F_MODE, 4'h0, "R7");
        tick(4);
        ocd_active = 1'b0; pd_req = 1'b0;
        expect_f(1, F_DEF, 4'h0, "R7"); expect_f(1, F_CKE, 4'h1, "R7");
        tick(2);

        // R8: self refresh refused while a bank is open
        bank_open = 8'h80; sr_req = 1'b1;
        expect_f(1, F_DEF, 4'h1, "R8"); expect_f(1, F_CKE, 4'h1, "R8");
        expect_f(3, F_CKE, 4'h1, "R8"); expect_f(3, F_MODE, 4'h0, "R8");
        tick(3);
        sr_req = 1'b0; bank_open = '0;
        tick(2);

        // R4 with both requests; then R9 / R10 exit windows
        sr_req = 1'b1; pd_req = 1'b1;
        expect_f(1, F_CKE, 4'h0, "R4"); expect_f(1, F_CMD, 4'h1, "R4");
        expect_f(1, F_MODE, 4'h3, "R4"); expect_f(1, F_RRDY, 4'h0, "R13");
        tick(1);
        pd_req = 1'b0;
        tick(4);
        sr_req = 1'b0;
        expect_f(1, F_CKE, 4'h1, "R9"); expect_f(1, F_CMD, 4'h7, "R9");
        expect_f(1, F_CRDY, 4'h0, "R9"); expect_f(1, F_MODE, 4'h0, "R9");
        expect_f(TXSNR, F_CMD, 4'h7, "R9"); expect_f(TXSNR, F_CRDY, 4'h0, "R9");
        expect_f(TXSNR + 1, F_CRDY, 4'h1, "R9"); expect_f(TXSNR + 1, F_RRDY, 4'h0, "R10");
        expect_f(TXSNR + 2, F_CMD, 4'hF, "R9");
        expect_f(TXSRD, F_RRDY, 4'h0, "R10"); expect_f(TXSRD + 1, F_RRDY, 4'h1, "R10");
        tick(TXSRD + 3);

        // R11: deadline expires in the same cycle the request drops
        pd_req = 1'b1;
        expect_f(1, F_CKE, 4'h0, "R11"); expect_f(1, F_MODE, 4'h2, "R11");
        expect_f(PDL, F_CKE, 4'h0, "R11");
        expect_f(PDL + 1, F_CKE, 4'h1, "R11"); expect_f(PDL + 1, F_CMD, 4'h7, "R11");
        expect_f(PDL + 2, F_CMD, 4'h1, "R11"); expect_f(PDL + 2, F_CKE, 4'h1, "R11");
        expect_f(PDL + 3, F_CMD, 4'hF, "R11");
        tick(PDL);
        pd_req = 1'b0;
        tick(6);

        // R12: forced exit from active power-down waits for banks to close
        bank_open = 8'h01; pd_req = 1'b1;
        expect_f(1, F_MODE, 4'h1, "R12");
        expect_f(PDL + 1, F_CKE, 4'h1, "R12"); expect_f(PDL + 1, F_CMD, 4'h7, "R12");
        expect_f(PDL + 2, F_CMD, 4'hF, "R12"); expect_f(PDL + 2, F_CRDY, 4'h1, "R12");
        tick(PDL + 1);
        pd_req = 1'b0;
        expect_f(2, F_CMD, 4'hF, "R12"); expect_f(3, F_CMD, 4'hF, "R12");
        tick(3);
        bank_open = '0;
        expect_f(1, F_CMD, 4'h1, "R12"); expect_f(1, F_CKE, 4'h1, "R12");
        expect_f(2, F_CMD, 4'hF, "R12"); expect_f(2, F_MODE, 4'h0, "R12");
        tick(4);

        tick(2);
        if (sb.size() != 0) begin
            errs += sb.size();
            checks += sb.size();
            $display("FAIL scoreboard: got %0d unmatched expectations expected 0", sb.size());
        end
        finish_run();
    end

endmodule